// File: doc/BRIEF.md
# Two-Pin Bidirectional GPIO Port

This block is a two-pin general-purpose I/O port that sits on the byte-wide bus of a small microcontroller. It holds two registers. The data register holds the output latch, and the direction register sets, pin by pin, whether the output driver is on. On a read, the data register returns the level seen on each pin. An output pin returns the level that the port drives, and an input pin returns its pad level after a two-flop synchronizer.

Single-bit set and clear operations use the stored latch and not the pins. A bit set or bit clear aimed at one pin therefore keeps every other latch bit as it was, even when that other pin is an input and reads a different level. The driver enables and output values go to tri-state pads outside the block. Both pins come out of reset as inputs.

Top module: `gpio2_port`

## Requirements
- R1: After reset both output enables are 0, the direction register reads 0x00 and the output latch holds 0.
- R2: A write to address 0x0061 loads the direction bits from wdata[1:0] on the next rising edge. A direction bit of 1 turns on that pin's output enable, and 0 turns it off. wdata[7:2] is ignored, and the register reads back as {6'b0, direction}.
- R3: A write to address 0x0060 loads the output latch from wdata[1:0] whatever the direction. pin_out carries the latch, and a pin drives it only while its output enable is 1.
- R4: A read of 0x0060 returns the latch bit for each output pin and the synchronized pad level for each input pin. rdata[7:2] always reads 0.
- R5: A pad level change on an input pin shows in data reads after the second rising edge and not after the first.
- R6: bit_op encodes 01 as set and 10 as clear. With wr_en low, a bit operation at address 0x0060 changes only latch bit bit_idx, and the other latch bits keep their stored values regardless of the pin levels.
- R7: The same set and clear operations at address 0x0061 change only direction bit bit_idx.
- R8: A bit operation with bit_idx from 2 to 7, or with bit_op equal to 00 or 11, changes no state.
- R9: Any address other than 0x0060 and 0x0061, including addresses that differ only in the upper byte, reads as 0x00 and changes no state on a write or bit operation.
- R10: While rd_en is low, rdata is 0x00.
- R11: When wr_en and a bit operation arrive in the same cycle, the full write wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | 16 | Byte address |
| wdata | input | 8 | Write data |
| wr_en | input | 1 | Full register write strobe |
| rd_en | input | 1 | Read strobe; rdata is valid in the same cycle |
| bit_op | input | 2 | Bit operation: 00 none, 01 set, 10 clear, 11 none |
| bit_idx | input | 3 | Target bit of a bit operation |
| rdata | output | 8 | Read data |
| pin_in | input | 2 | Pad input levels (asynchronous) |
| pin_out | output | 2 | Output latch value to the pads |
| pin_oe | output | 2 | Per-pin pad driver enable |

## Verification
A corrupted direction bit shows on pin_oe one edge after the access that caused it. It also changes which source the data read returns for that pin. A latch bit disturbed by a bit operation on its neighbour shows on pin_out at the next edge. Because the data read for an input pin hides the latch, the bench checks pin_out directly and does not rely on reads. A synchronizer with the wrong depth shows as a pad change that reaches the read one edge too early or too late, so the bench reads both after the first edge and after the second.

// File: rtl/gpio2_pkg.sv
package gpio2_pkg;
  localparam int ADDR_W = 16;
  localparam int DATA_W = 8;
  localparam int IDX_W  = 3;

  typedef enum logic [1:0] {
    BOP_NONE = 2'b00,
    BOP_SET  = 2'b01,
    BOP_CLR  = 2'b10,
    BOP_RSVD = 2'b11
  } bitop_e;
endpackage

// File: rtl/gpio2_decode.sv
module gpio2_decode #(
  parameter int          AW        = 16,
  parameter logic [15:0] DATA_ADDR = 16'h0060,
  parameter logic [15:0] DIR_ADDR  = 16'h0061
) (
  input  logic [AW-1:0] addr,
  output logic          data_hit,
  output logic          dir_hit
);
  // Full compare: no aliasing in the upper address byte.
  always_comb begin
    data_hit = (addr == DATA_ADDR[AW-1:0]);
    dir_hit  = (addr == DIR_ADDR[AW-1:0]);
  end
endmodule

// File: rtl/gpio2_sync.sv
module gpio2_sync #(
  parameter int W      = 2,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stage_q [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          stage_q[s] <= '0;
        end else if (s == 0) begin
          stage_q[s] <= d;
        end else begin
          stage_q[s] <= stage_q[(s == 0) ? 0 : s-1];
        end
      end
    end
  endgenerate

  assign q = stage_q[STAGES-1];
endmodule

// File: rtl/gpio2_ctl_reg.sv
module gpio2_ctl_reg
  import gpio2_pkg::*;
#(
  parameter int           W       = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sel,
  input  logic             wr_en,
  input  logic [W-1:0]     wdata,
  input  logic [1:0]       bit_op,
  input  logic [IDX_W-1:0] bit_idx,
  output logic [W-1:0]     q,
  output logic             upd
);
  // Bit operation on the stored value only; out-of-range index is a no-op.
  function automatic logic [W-1:0] apply_bitop(
    input logic [W-1:0]     cur,
    input logic [1:0]       op,
    input logic [IDX_W-1:0] idx
  );
    logic [W-1:0] nxt;
    nxt = cur;
    for (int i = 0; i < W; i++) begin
      if (int'(idx) == i) begin
        if (op == BOP_SET) nxt[i] = 1'b1;
        if (op == BOP_CLR) nxt[i] = 1'b0;
      end
    end
    return nxt;
  endfunction

  logic         bop_live;
  logic [W-1:0] q_next;

  always_comb begin
    bop_live = (bit_op == BOP_SET) || (bit_op == BOP_CLR);
    upd      = sel && (wr_en || bop_live);
    if (wr_en) q_next = wdata;
    else       q_next = apply_bitop(q, bit_op, bit_idx);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   q <= RST_VAL;
    else if (upd) q <= q_next;
  end
endmodule

// File: rtl/gpio2_port.sv
module gpio2_port
  import gpio2_pkg::*;
#(
  parameter int          PINS      = 2,
  parameter logic [15:0] DATA_ADDR = 16'h0060,
  parameter logic [15:0] DIR_ADDR  = 16'h0061,
  parameter int          SYNC_LEN  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [1:0]        bit_op,
  input  logic [IDX_W-1:0]  bit_idx,
  output logic [DATA_W-1:0] rdata,
  input  logic [PINS-1:0]   pin_in,
  output logic [PINS-1:0]   pin_out,
  output logic [PINS-1:0]   pin_oe
);
  localparam int PAD_W = DATA_W - PINS;

  // Output pins show their driven latch; input pins show the synchronized pad.
  function automatic logic [PINS-1:0] pin_view(
    input logic [PINS-1:0] latch,
    input logic [PINS-1:0] dir,
    input logic [PINS-1:0] pads
  );
    return (dir & latch) | (~dir & pads);
  endfunction

  logic            data_hit, dir_hit;
  logic            data_upd, dir_upd;
  logic [PINS-1:0] latch_q, dir_q, pin_sync;

  gpio2_decode #(
    .AW(ADDR_W), .DATA_ADDR(DATA_ADDR), .DIR_ADDR(DIR_ADDR)
  ) u_dec (
    .addr(addr), .data_hit(data_hit), .dir_hit(dir_hit)
  );

  gpio2_ctl_reg #(.W(PINS), .RST_VAL('0)) u_latch (
    .clk(clk), .rst_n(rst_n), .sel(data_hit), .wr_en(wr_en),
    .wdata(wdata[PINS-1:0]), .bit_op(bit_op), .bit_idx(bit_idx),
    .q(latch_q), .upd(data_upd)
  );

  gpio2_ctl_reg #(.W(PINS), .RST_VAL('0)) u_dir (
    .clk(clk), .rst_n(rst_n), .sel(dir_hit), .wr_en(wr_en),
    .wdata(wdata[PINS-1:0]), .bit_op(bit_op), .bit_idx(bit_idx),
    .q(dir_q), .upd(dir_upd)
  );

  gpio2_sync #(.W(PINS), .STAGES(SYNC_LEN)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(pin_in), .q(pin_sync)
  );

  always_comb begin
    rdata = '0;
    if (rd_en && data_hit)     rdata = {{PAD_W{1'b0}}, pin_view(latch_q, dir_q, pin_sync)};
    else if (rd_en && dir_hit) rdata = {{PAD_W{1'b0}}, dir_q};
  end

  assign pin_out = latch_q;
  assign pin_oe  = dir_q;
endmodule

// File: rtl/gpio2_port_chk.sv
module gpio2_port_chk #(
  parameter int W = 2
) (
  input logic         clk,
  input logic         rst_n,
  input logic         rd_en,
  input logic         wr_en,
  input logic [1:0]   bit_op,
  input logic [2:0]   bit_idx,
  input logic [7:0]   rdata,
  input logic [W-1:0] pin_out,
  input logic [W-1:0] pin_oe,
  input logic         data_hit,
  input logic         dir_hit,
  input logic         data_upd,
  input logic         dir_upd
);
  assert_reset_oe_R1: assert property (@(posedge clk) $rose(rst_n) |-> pin_oe == '0);
  assert_oe_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !dir_upd |=> $stable(pin_oe));
  assert_latch_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !data_upd |=> $stable(pin_out));
  assert_upper_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
    rdata[7:W] == '0);
  assert_bitop_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (data_hit && !wr_en && (bit_op == 2'b01 || bit_op == 2'b10))
    |=> $countones(pin_out ^ $past(pin_out)) <= 1);
  assert_bitop_range_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (data_hit && !wr_en && (int'(bit_idx) >= W)) |=> $stable(pin_out));
  assert_miss_read_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && !data_hit && !dir_hit) |-> rdata == '0);
  assert_idle_read_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |-> rdata == '0);
endmodule

bind gpio2_port gpio2_port_chk #(.W(PINS)) u_chk (
  .clk(clk), .rst_n(rst_n), .rd_en(rd_en), .wr_en(wr_en),
  .bit_op(bit_op), .bit_idx(bit_idx), .rdata(rdata),
  .pin_out(pin_out), .pin_oe(pin_oe), .data_hit(data_hit),
  .dir_hit(dir_hit), .data_upd(data_upd), .dir_upd(dir_upd)
);

// File: tb/gpio2_port_tb_top.sv
module gpio2_port_tb_top;
  localparam logic [15:0] A_DATA = 16'h0060;
  localparam logic [15:0] A_DIR  = 16'h0061;
  localparam logic [1:0]  OP_NO  = 2'b00;
  localparam logic [1:0]  OP_SET = 2'b01;
  localparam logic [1:0]  OP_CLR = 2'b10;
  localparam logic [1:0]  OP_RES = 2'b11;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] addr = '0;
  logic [7:0]  wdata = '0;
  logic        wr_en = 1'b0, rd_en = 1'b0;
  logic [1:0]  bit_op = '0;
  logic [2:0]  bit_idx = '0;
  logic [7:0]  rdata;
  logic [1:0]  pin_in = '0;
  logic [1:0]  pin_out, pin_oe;

  int checks = 0;
  int errors = 0;
  logic [7:0] exp_q[$];
  string      tag_q[$];

  always #10 clk = ~clk;

  gpio2_port dut_i (
    .clk(clk), .rst_n(rst_n), .addr(addr), .wdata(wdata), .wr_en(wr_en),
    .rd_en(rd_en), .bit_op(bit_op), .bit_idx(bit_idx), .rdata(rdata),
    .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe)
  );

  // Reference view of a data read.
  function automatic logic [7:0] exp_read(logic [1:0] lat, logic [1:0] dir, logic [1:0] pads);
    return {6'b0, (lat & dir) | (pads & ~dir)};
  endfunction

  task automatic drive(logic [15:0] a, logic [7:0] d, logic w, logic [1:0] op, logic [2:0] idx);
    @(negedge clk);
    addr = a; wdata = d; wr_en = w; rd_en = 1'b0; bit_op = op; bit_idx = idx;
  endtask

  task automatic idle();
    drive(16'h0000, 8'h00, 1'b0, OP_NO, 3'd0);
  endtask

  task automatic rd(logic [15:0] a, logic en, logic [7:0] exp, string tag);
    @(negedge clk);
    addr = a; wdata = '0; wr_en = 1'b0; rd_en = en; bit_op = OP_NO; bit_idx = '0;
    exp_q.push_back(exp);
    tag_q.push_back(tag);
  endtask

  // Pads are sampled in the low phase following the access edge.
  task automatic chk_pads(logic [1:0] eo, logic [1:0] ee, string tag);
    idle();
    #4;
    checks++;
    if (pin_out !== eo || pin_oe !== ee) begin
      errors++;
      $display("FAIL %s pin_out=%b oe=%b expected pin_out=%b oe=%b", tag, pin_out, pin_oe, eo, ee);
    end
  endtask

  // Scoreboard monitor.
  initial begin
    forever begin
      @(negedge clk);
      #5;
      if (exp_q.size() > 0) begin
        logic [7:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        checks++;
        if (rdata !== e) begin
          errors++;
          $display("FAIL %s rdata=%h expected %h", t, rdata, e);
        end
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    // R1 reset state
    chk_pads(2'b00, 2'b00, "R1 reset pads");
    rd(A_DIR, 1'b1, 8'h00, "R1 reset direction");
    // R4 input pins read synchronized pads
    pin_in = 2'b10;
    idle(); idle();
    rd(A_DATA, 1'b1, exp_read(2'b00, 2'b00, 2'b10), "R4 input pins read pads");
    // R3 latch loads while inputs; pads not driven
    drive(A_DATA, 8'hFF, 1'b1, OP_NO, 3'd0);
    chk_pads(2'b11, 2'b00, "R3 latch load as inputs");
    rd(A_DATA, 1'b1, 8'h02, "R4 latch hidden on inputs");
    // R2 direction write, upper bits ignored
    drive(A_DIR, 8'hFF, 1'b1, OP_NO, 3'd0);
    chk_pads(2'b11, 2'b11, "R2 direction enables");
    rd(A_DIR, 1'b1, 8'h03, "R2 upper direction bits ignored");
    rd(A_DATA, 1'b1, exp_read(2'b11, 2'b11, 2'b10), "R4 output pins read latch");
    drive(A_DIR, 8'h01, 1'b1, OP_NO, 3'd0);
    chk_pads(2'b11, 2'b01, "R2 pin1 back to input");
    pin_in = 2'b00;
    idle(); idle();
    rd(A_DATA, 1'b1, exp_read(2'b11, 2'b01, 2'b00), "R4 mixed directions");
    // R6 bit ops use the latch, not the pins (pin1 reads 0, latch1 is 1)
    drive(A_DATA, 8'h00, 1'b0, OP_CLR, 3'd0);
    chk_pads(2'b10, 2'b01, "R6 clear bit0 keeps latch bit1");
    drive(A_DATA, 8'h00, 1'b0, OP_SET, 3'd0);
    chk_pads(2'b11, 2'b01, "R6 set bit0");
    drive(A_DATA, 8'h00, 1'b0, OP_CLR, 3'd1);
    chk_pads(2'b01, 2'b01, "R6 clear bit1 keeps bit0");
    // R8 out-of-range index and null op codes
    drive(A_DATA, 8'h00, 1'b0, OP_SET, 3'd5);
    chk_pads(2'b01, 2'b01, "R8 index 5 ignored");
    drive(A_DATA, 8'h00, 1'b0, OP_RES, 3'd1);
    chk_pads(2'b01, 2'b01, "R8 op 11 ignored");
    drive(A_DIR, 8'h00, 1'b0, OP_CLR, 3'd7);
    chk_pads(2'b01, 2'b01, "R8 direction index 7 ignored");
    // R7 bit ops on the direction register
    drive(A_DIR, 8'h00, 1'b0, OP_SET, 3'd1);
    chk_pads(2'b01, 2'b11, "R7 set direction bit1");
    drive(A_DIR, 8'h00, 1'b0, OP_CLR, 3'd0);
    chk_pads(2'b01, 2'b10, "R7 clear direction bit0");
    // R9 other addresses
    drive(16'h0062, 8'hFF, 1'b1, OP_NO, 3'd0);
    chk_pads(2'b01, 2'b10, "R9 write to 0x0062 ignored");
    drive(16'h0160, 8'hFF, 1'b1, OP_NO, 3'd0);
    chk_pads(2'b01, 2'b10, "R9 write to 0x0160 ignored");
    drive(16'h0161, 8'h00, 1'b0, OP_SET, 3'd0);
    chk_pads(2'b01, 2'b10, "R9 bit op at 0x0161 ignored");
    rd(16'h0062, 1'b1, 8'h00, "R9 read 0x0062");
    rd(16'h0161, 1'b1, 8'h00, "R9 read 0x0161");
    // R10 no read strobe
    rd(A_DIR, 1'b0, 8'h00, "R10 rd_en low");
    // R11 write beats bit op
    drive(A_DATA, 8'h00, 1'b1, OP_SET, 3'd0);
    chk_pads(2'b00, 2'b10, "R11 write wins over set");
    // R5 synchronizer depth: pin0 is an input now
    pin_in = 2'b01;
    @(negedge clk);
    addr = A_DATA; rd_en = 1'b1;
    exp_q.push_back(exp_read(2'b00, 2'b10, 2'b00));
    tag_q.push_back("R5 not visible after one edge");
    rd(A_DATA, 1'b1, exp_read(2'b00, 2'b10, 2'b01), "R5 visible after two edges");
    idle(); idle();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule